// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block drives the hold and squash controls of a five-stage in-order processor. The stages are fetch, decode, execute, memory and writeback. It looks at the opcodes now in decode, execute and memory. It also looks at the register that a load in execute will write, the two registers that decode is reading, and the branch outcome resolved in execute. From these it decides, for every pipeline register, whether that register loads normally, holds its contents (stall) or loads a no-op (bubble). The decision is purely combinational. It takes effect at the next rising clock edge.

Three hazards are resolved. The first is a load followed by a use of the loaded register, which costs one cycle. The second is a conditional branch found not taken, since branches are predicted taken; it costs two cycles. The third is a return travelling down the pipe, which costs three cycles. The block also resolves the cases where two of these occur together. When a load-use hazard and a pending return coincide, the load-use hazard wins. The return then waits one extra cycle in decode, and decode is never held and squashed in the same cycle.

For observation, the block contains a chain of parameterised pipeline registers that carry instruction tokens. A token enters at fetch. The chain obeys the same stall and bubble controls, so the flow of instructions can be tracked at the ports.

Top module: `hzd_ctrl_top`

## Requirements
- R1: A load-use hazard exists when the execute opcode is 5 (load) or 11 (pop), the execute destination register equals decode source A or decode source B, and that destination is not 15. It gives fetch stall, decode stall and execute bubble, with no decode bubble. Control bits are indexed fetch=0, decode=1, execute=2, memory=3, writeback=4.
- R2: The register code 15 means "no register". An execute destination of 15 never causes a stall, whatever the source registers are.
- R3: An execute opcode of 7 (conditional jump) with the taken flag at 0 gives decode bubble and execute bubble. With the taken flag at 1, the jump requests no control at all.
- R4: An opcode of 9 (return) in decode, execute or memory gives fetch stall and decode bubble when no load-use hazard exists.
- R5: When a load-use hazard and a pending return coincide, the outputs are fetch stall, decode stall and execute bubble, with no decode bubble.
- R6: When a not-taken jump is in execute and a return is pending, the outputs are fetch stall, decode bubble and execute bubble.
- R7: The memory and writeback registers are never stalled or bubbled. No register ever receives stall and bubble together.
- R8: Each token register clears to 0 under reset. At a clock edge it holds under stall, loads the no-op token 0 under bubble, and otherwise loads its upstream neighbour (fetch loads the token input).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_op | input | OPW | Opcode held in decode |
| exe_op | input | OPW | Opcode held in execute |
| mem_op | input | OPW | Opcode held in memory |
| exe_dst_mem | input | RW | Register the execute instruction writes from memory |
| dec_src_a | input | RW | First register read in decode |
| dec_src_b | input | RW | Second register read in decode |
| exe_br_taken | input | 1 | Branch condition outcome from execute |
| fetch_tok_in | input | TW | Token entering the fetch register |
| ctl_stall | output | 5 | Per-register hold request, bit 0 fetch to bit 4 writeback |
| ctl_bubble | output | 5 | Per-register no-op inject request, same order |
| stage_tok | output | 5*TW | Token held in each register, fetch in the lowest slice |

## Verification
On every cycle, the assertions check that no register is both stalled and bubbled and that memory and writeback are always left alone. They also check that a decode stall always comes with a fetch stall and an execute bubble, that the no-register code never stalls decode, and that each token register really holds, clears or passes on as commanded. The exact control pattern for each single hazard and for each combination, including load-use priority over a pending return, is shown only by the bench. It sweeps the opcode, register and branch-outcome space. It then runs token sequences through the chain and compares every stage against an arithmetic model.

// File: rtl/hzd_pkg.sv
// Package: shared stage indices and hazard flag type for the hazard control unit.
// Assumes a fixed five-register in-order pipeline.
package hzd_pkg;
    localparam int NUM_STAGES = 5;
    localparam int STG_F = 0;
    localparam int STG_D = 1;
    localparam int STG_E = 2;
    localparam int STG_M = 3;
    localparam int STG_W = 4;

    typedef struct packed {
        logic load_use;
        logic mispredict;
        logic ret_pending;
    } hzd_flags_t;
endpackage

// File: rtl/hzd_detect.sv
// Module: hzd_detect
// Finds the three hazard conditions from the current stage contents.
// Assumes the all-ones register code means "no register".
module hzd_detect
    import hzd_pkg::*;
#(
    parameter int OPW = 4,
    parameter int RW  = 4,
    parameter logic [OPW-1:0] OP_LOAD = 4'd5,
    parameter logic [OPW-1:0] OP_POP  = 4'd11,
    parameter logic [OPW-1:0] OP_JCC  = 4'd7,
    parameter logic [OPW-1:0] OP_RET  = 4'd9
) (
    input  logic [OPW-1:0] dec_op,
    input  logic [OPW-1:0] exe_op,
    input  logic [OPW-1:0] mem_op,
    input  logic [RW-1:0]  exe_dst_mem,
    input  logic [RW-1:0]  dec_src_a,
    input  logic [RW-1:0]  dec_src_b,
    input  logic           exe_br_taken,
    output hzd_flags_t     flags
);
    localparam logic [RW-1:0] NO_REG = '1;

    logic exe_reads_mem;
    logic dst_valid;
    logic src_hit;

    // Purpose: classify execute instruction and compare its load target with decode sources.
    always_comb begin
        exe_reads_mem = (exe_op == OP_LOAD) || (exe_op == OP_POP);
        dst_valid     = (exe_dst_mem != NO_REG);
        src_hit       = (exe_dst_mem == dec_src_a) || (exe_dst_mem == dec_src_b);
    end

    // Purpose: assemble the hazard flags.
    always_comb begin
        flags.load_use    = exe_reads_mem && dst_valid && src_hit;
        flags.mispredict  = (exe_op == OP_JCC) && !exe_br_taken;
        flags.ret_pending = (dec_op == OP_RET) || (exe_op == OP_RET) || (mem_op == OP_RET);
    end
endmodule

// File: rtl/hzd_resolve.sv
// Module: hzd_resolve
// Turns hazard flags into per-register stall and bubble controls,
// giving load-use priority over a pending return at decode.
// Assumes flags are already stable for the current cycle.
module hzd_resolve
    import hzd_pkg::*;
(
    input  hzd_flags_t              flags,
    output logic [NUM_STAGES-1:0]   stall,
    output logic [NUM_STAGES-1:0]   bubble
);
    // Purpose: map each hazard to the registers it affects.
    always_comb begin
        stall  = '0;
        bubble = '0;
        stall[STG_F]  = flags.load_use || flags.ret_pending;
        stall[STG_D]  = flags.load_use;
        bubble[STG_D] = flags.mispredict || (flags.ret_pending && !flags.load_use);
        bubble[STG_E] = flags.mispredict || flags.load_use;
    end
endmodule

// File: rtl/hzd_stage_reg.sv
// Module: hzd_stage_reg
// Generic pipeline register with hold and no-op inject; hold wins if both arrive.
// Assumes the no-op value is all zeros.
module hzd_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         inject,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Purpose: clear, hold, squash or load on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (hold)   q <= q;
        else if (inject) q <= '0;
        else             q <= d;
    end
endmodule

// File: rtl/hzd_ctrl_top.sv
// Module: hzd_ctrl_top
// Pipeline hazard control unit: combinational stall/bubble generation plus a
// token chain of pipeline registers that obeys those controls.
// Assumes stage contents at the ports are the values held this cycle.
module hzd_ctrl_top
    import hzd_pkg::*;
#(
    parameter int OPW = 4,
    parameter int RW  = 4,
    parameter int TW  = 8,
    parameter logic [OPW-1:0] OP_LOAD = 4'd5,
    parameter logic [OPW-1:0] OP_POP  = 4'd11,
    parameter logic [OPW-1:0] OP_JCC  = 4'd7,
    parameter logic [OPW-1:0] OP_RET  = 4'd9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [OPW-1:0]            dec_op,
    input  logic [OPW-1:0]            exe_op,
    input  logic [OPW-1:0]            mem_op,
    input  logic [RW-1:0]             exe_dst_mem,
    input  logic [RW-1:0]             dec_src_a,
    input  logic [RW-1:0]             dec_src_b,
    input  logic                      exe_br_taken,
    input  logic [TW-1:0]             fetch_tok_in,
    output logic [NUM_STAGES-1:0]     ctl_stall,
    output logic [NUM_STAGES-1:0]     ctl_bubble,
    output logic [NUM_STAGES*TW-1:0]  stage_tok
);
    hzd_flags_t flags;
    logic [TW-1:0] tok_q [NUM_STAGES];

    hzd_detect #(
        .OPW(OPW), .RW(RW),
        .OP_LOAD(OP_LOAD), .OP_POP(OP_POP), .OP_JCC(OP_JCC), .OP_RET(OP_RET)
    ) u_detect (
        .dec_op(dec_op), .exe_op(exe_op), .mem_op(mem_op),
        .exe_dst_mem(exe_dst_mem), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .exe_br_taken(exe_br_taken), .flags(flags)
    );

    hzd_resolve u_resolve (
        .flags(flags), .stall(ctl_stall), .bubble(ctl_bubble)
    );

    // Purpose: one token register per stage, each fed by its upstream neighbour.
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        logic [TW-1:0] d_in;
        if (g == 0) begin : g_head
            assign d_in = fetch_tok_in;
        end else begin : g_body
            assign d_in = tok_q[g-1];
        end
        hzd_stage_reg #(.W(TW)) u_reg (
            .clk(clk), .rst_n(rst_n),
            .hold(ctl_stall[g]), .inject(ctl_bubble[g]),
            .d(d_in), .q(tok_q[g])
        );
        assign stage_tok[g*TW +: TW] = tok_q[g];
    end
endmodule

// File: rtl/hzd_ctrl_chk.sv
// Module: hzd_ctrl_chk
// Property checker for hzd_ctrl_top, attached with bind below.
module hzd_ctrl_chk
    import hzd_pkg::*;
#(
    parameter int OPW = 4,
    parameter int RW  = 4,
    parameter int TW  = 8,
    parameter logic [OPW-1:0] OP_RET = 4'd9
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [OPW-1:0]            dec_op,
    input logic [OPW-1:0]            exe_op,
    input logic [OPW-1:0]            mem_op,
    input logic [RW-1:0]             exe_dst_mem,
    input logic [NUM_STAGES-1:0]     ctl_stall,
    input logic [NUM_STAGES-1:0]     ctl_bubble,
    input logic [NUM_STAGES*TW-1:0]  stage_tok
);
    localparam logic [RW-1:0] NO_REG = '1;

    assert_never_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_stall & ctl_bubble) == '0);

    assert_late_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_stall[STG_M] && !ctl_stall[STG_W] && !ctl_bubble[STG_M] && !ctl_bubble[STG_W]);

    assert_dstall_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_stall[STG_D] |-> (ctl_stall[STG_F] && ctl_bubble[STG_E]));

    assert_noreg_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_dst_mem == NO_REG) |-> !ctl_stall[STG_D]);

    assert_ret_holds_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_op == OP_RET) || (exe_op == OP_RET) || (mem_op == OP_RET)) |-> ctl_stall[STG_F]);

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_flow
        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_stall[k] |=> $stable(stage_tok[k*TW +: TW]));
        assert_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_bubble[k] && !ctl_stall[k]) |=> (stage_tok[k*TW +: TW] == '0));
        if (k > 0) begin : g_pass
            assert_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (!ctl_stall[k] && !ctl_bubble[k]) |=>
                    (stage_tok[k*TW +: TW] == $past(stage_tok[(k-1)*TW +: TW])));
        end
    end
endmodule

bind hzd_ctrl_top hzd_ctrl_chk #(
    .OPW(OPW), .RW(RW), .TW(TW), .OP_RET(OP_RET)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dec_op(dec_op), .exe_op(exe_op), .mem_op(mem_op),
    .exe_dst_mem(exe_dst_mem), .ctl_stall(ctl_stall), .ctl_bubble(ctl_bubble),
    .stage_tok(stage_tok)
);

// File: tb/test_hzd_ctrl_top.sv
// Bench: sweeps opcode/register/branch space for the control pattern, then
// runs token sequences through the chain against an arithmetic model.
module test_hzd_ctrl_top;
    localparam int TW = 8;
    localparam int NS = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] dec_op = 0, exe_op = 0, mem_op = 0;
    logic [3:0] exe_dst_mem = 0, dec_src_a = 0, dec_src_b = 0;
    logic exe_br_taken = 1'b0;
    logic [TW-1:0] fetch_tok_in = 0;
    logic [NS-1:0] ctl_stall, ctl_bubble;
    logic [NS*TW-1:0] stage_tok;

    int checks = 0;
    int errors = 0;
    logic [TW-1:0] exp_tok [NS];

    hzd_ctrl_top i_hzd_ctrl_top (
        .clk(clk), .rst_n(rst_n), .dec_op(dec_op), .exe_op(exe_op), .mem_op(mem_op),
        .exe_dst_mem(exe_dst_mem), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .exe_br_taken(exe_br_taken), .fetch_tok_in(fetch_tok_in),
        .ctl_stall(ctl_stall), .ctl_bubble(ctl_bubble), .stage_tok(stage_tok)
    );

    always #4 clk = ~clk;

    // Expected {bubble, stall} from the requirements text.
    function automatic logic [9:0] exp_ctl(input logic [3:0] d, e, m, dst, sa, sb, input logic tk);
        logic lu, mis, rt;
        logic [4:0] s, b;
        lu  = ((e == 4'd5) || (e == 4'd11)) && (dst != 4'd15) && ((dst == sa) || (dst == sb));
        mis = (e == 4'd7) && !tk;
        rt  = (d == 4'd9) || (e == 4'd9) || (m == 4'd9);
        s = 5'b0; b = 5'b0;
        if (lu) begin s[0] = 1; s[1] = 1; b[2] = 1; end
        if (mis) begin b[1] = 1; b[2] = 1; end
        if (rt) begin
            s[0] = 1;
            if (!lu) b[1] = 1;
        end
        return {b, s};
    endfunction

    function automatic string tag_of(input logic [3:0] d, e, m, dst, sa, sb, input logic tk);
        logic lu, mis, rt;
        lu  = ((e == 4'd5) || (e == 4'd11)) && (dst != 4'd15) && ((dst == sa) || (dst == sb));
        mis = (e == 4'd7) && !tk;
        rt  = (d == 4'd9) || (e == 4'd9) || (m == 4'd9);
        if (lu && rt)  return "R5";
        if (mis && rt) return "R6";
        if (lu)        return "R1";
        if (mis)       return "R3";
        if (rt)        return "R4";
        if (dst == 4'd15) return "R2";
        return "R7";
    endfunction

    task automatic check_ctl();
        logic [9:0] e;
        e = exp_ctl(dec_op, exe_op, mem_op, exe_dst_mem, dec_src_a, dec_src_b, exe_br_taken);
        checks++;
        if ({ctl_bubble, ctl_stall} !== e) begin
            errors++;
            $display("FAIL %s ctl: d=%0d e=%0d m=%0d dst=%0d sa=%0d sb=%0d tk=%0d got=%b exp=%b",
                tag_of(dec_op, exe_op, mem_op, exe_dst_mem, dec_src_a, dec_src_b, exe_br_taken),
                dec_op, exe_op, mem_op, exe_dst_mem, dec_src_a, dec_src_b, exe_br_taken,
                {ctl_bubble, ctl_stall}, e);
        end
    endtask

    task automatic check_tokens(input string tag);
        for (int k = 0; k < NS; k++) begin
            checks++;
            if (stage_tok[k*TW +: TW] !== exp_tok[k]) begin
                errors++;
                $display("FAIL %s stage %0d token got=%0d exp=%0d", tag, k, stage_tok[k*TW +: TW], exp_tok[k]);
            end
        end
    endtask

    // One cycle of flow: drive after negedge, check controls, advance model, check at next negedge.
    task automatic step(input logic [3:0] d, e, m, dst, sa, sb, input logic tk, input logic [TW-1:0] tin);
        logic [9:0] c;
        logic [TW-1:0] old [NS];
        dec_op = d; exe_op = e; mem_op = m; exe_dst_mem = dst;
        dec_src_a = sa; dec_src_b = sb; exe_br_taken = tk; fetch_tok_in = tin;
        #1;
        check_ctl();
        c = exp_ctl(d, e, m, dst, sa, sb, tk);
        for (int k = 0; k < NS; k++) old[k] = exp_tok[k];
        for (int k = 0; k < NS; k++) begin
            if (c[k])          exp_tok[k] = old[k];
            else if (c[5+k])   exp_tok[k] = '0;
            else               exp_tok[k] = (k == 0) ? tin : old[k-1];
        end
        @(posedge clk);
        @(negedge clk);
        check_tokens("R8");
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [3:0] ops [5];
        logic [3:0] sas [3];
        logic [3:0] sbs [2];
        logic [3:0] dsts [2];
        ops[0] = 0; ops[1] = 5; ops[2] = 11; ops[3] = 7; ops[4] = 9;
        sas[0] = 1; sas[1] = 2; sas[2] = 15;
        sbs[0] = 1; sbs[1] = 3;
        dsts[0] = 1; dsts[1] = 15;
        for (int k = 0; k < NS; k++) exp_tok[k] = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Reset state of tokens and idle controls (R8, R7).
        check_tokens("R8");
        check_ctl();

        // Near-exhaustive control sweep: R1..R7.
        for (int id = 0; id < 5; id++)
            for (int ie = 0; ie < 5; ie++)
                for (int im = 0; im < 5; im++)
                    for (int idst = 0; idst < 2; idst++)
                        for (int ia = 0; ia < 3; ia++)
                            for (int ib = 0; ib < 2; ib++)
                                for (int it = 0; it < 2; it++) begin
                                    dec_op = ops[id]; exe_op = ops[ie]; mem_op = ops[im];
                                    exe_dst_mem = dsts[idst]; dec_src_a = sas[ia];
                                    dec_src_b = sbs[ib]; exe_br_taken = it[0];
                                    #1;
                                    check_ctl();
                                end

        // R2 directed: no-register destination matching both sources of all ones.
        dec_op = 0; exe_op = 5; mem_op = 0; exe_dst_mem = 15; dec_src_a = 15; dec_src_b = 15;
        #1;
        checks++;
        if (ctl_stall !== 5'b0 || ctl_bubble !== 5'b0) begin
            errors++;
            $display("FAIL R2 noreg got stall=%b bubble=%b exp=0/0", ctl_stall, ctl_bubble);
        end

        // Token flow scenarios (R8): normal, load-use, mispredict, return, combinations.
        @(negedge clk);
        for (int i = 1; i <= 6; i++) step(0, 0, 0, 0, 0, 0, 1, TW'(i));
        step(0, 5, 0, 2, 2, 4, 0, 8'd20);   // load-use R1
        step(0, 0, 0, 0, 0, 0, 0, 8'd21);
        step(0, 7, 0, 0, 0, 0, 0, 8'd22);   // mispredict R3
        step(0, 7, 0, 0, 0, 0, 1, 8'd23);   // taken R3
        step(9, 0, 0, 0, 0, 0, 0, 8'd24);   // return R4
        step(0, 9, 0, 0, 0, 0, 0, 8'd25);
        step(0, 0, 9, 0, 0, 0, 0, 8'd26);
        step(9, 11, 0, 3, 1, 3, 0, 8'd27);  // R5
        step(9, 7, 0, 0, 0, 0, 0, 8'd28);   // R6
        step(0, 5, 9, 15, 15, 15, 0, 8'd29); // R2 with return
        for (int i = 30; i <= 36; i++) step(0, 0, 0, 0, 0, 0, 1, TW'(i));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule